// File: doc/BRIEF.md
# Strobe-Clocked Read Capture Deserializer

This block receives a source-synchronous parallel bus whose data arrive together with a strobe that has already been gated and phase-shifted upstream. Each bus value is captured either on both strobe edges (double rate) or on the rising edge only (single rate). A fixed number of captured beats is packed into one wide word. The word goes into a small asynchronous FIFO on the same strobe edge that captured its final beat, so moving data from capture into storage costs no extra cycle.

On the core side, a read enable pops one word per core clock. In a full read path that enable comes from a latency-matching pipeline. A popped word appears on the parallel output one core cycle later, together with a valid pulse. Two sticky flags record misuse: writing a word while the FIFO is full, and popping while it is empty. Both flags clear only on reset.

Top module: `strobe_rd_deser`

## Requirements
- R1: After reset, `rd_empty` is 1, and `rd_valid`, `overflow` and `underflow` are 0.
- R2: In double-rate mode, the beat captured on a rising strobe edge goes to an even slot and the beat captured on the falling edge that follows goes to the next odd slot. The first beat of a word lands in slot 0, which is bits [DW-1:0] of `rd_data`, and beat k lands in bits [k*DW +: DW].
- R3: A word is written into the FIFO on the strobe edge that carries its last beat. `rd_empty` falls within three core clock edges after that strobe edge, and no further strobe edge is needed.
- R4: In single-rate mode, one beat is captured per rising strobe edge and falling edges are ignored. Beats fill the slots in order, starting at slot 0.
- R5: When `rd_en` is sampled high on a core edge and the FIFO is not empty, the oldest word appears on `rd_data` and `rd_valid` is 1 after that edge. Words leave in the order they were written. `rd_valid` is 0 after every other core edge.
- R6: When `rd_en` is sampled high while the FIFO is empty, `underflow` sets and stays set, `rd_valid` stays 0, and `rd_data` keeps its previous value.
- R7: A word completed while the FIFO holds DEPTH words is dropped, and `overflow` sets and stays set. The stored words come out unchanged.
- R8: The write and read pointers cross clock domains in Gray code, so each pointer changes at most one bit per clock edge.
- R9: A word that is only partly captured stays pending while the strobe is idle, and beats from a later burst complete it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| strobe | input | 1 | Gated, phase-shifted capture strobe |
| pin_data | input | DW | Data bus from the external device |
| core_clk | input | 1 | Core-side clock |
| rd_en | input | 1 | Pop request, sampled on core_clk |
| rd_data | output | BEATS*DW | Popped word, slot 0 in the low bits |
| rd_valid | output | 1 | High for one cycle after a successful pop |
| rd_empty | output | 1 | FIFO empty, as seen from the core domain |
| overflow | output | 1 | Sticky: a word was dropped because the FIFO was full (strobe domain) |
| underflow | output | 1 | Sticky: a pop was requested while the FIFO was empty |

## Verification
Double-rate words are sent with several data patterns: an incrementing sequence, walking ones, alternating 0xAA/0x55 and random values. The incrementing sequence exposes any swap between even and odd slots, and walking ones exposes a shifted slot boundary. A word split across two bursts shows whether pending beats survive an idle strobe. A single-rate instance receives its own beat series to show that falling edges are ignored. The FIFO is also driven past full and popped when empty, to show that the stored contents survive both misuse cases.

// File: rtl/scd_pkg.sv
package scd_pkg;
   typedef enum logic {CAP_SDR = 1'b0, CAP_DDR = 1'b1} cap_mode_e;
   localparam int MAX_BEATS = 8;
endpackage

// File: rtl/scd_sync.sv
module scd_sync #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/scd_capture.sv
module scd_capture
   import scd_pkg::*;
#(
   parameter int        DW    = 8,
   parameter int        BEATS = 8,
   parameter cap_mode_e MODE  = CAP_DDR
) (
   input  logic                strobe,
   input  logic                rst_n,
   input  logic [DW-1:0]       pin_data,
   input  logic                full,
   output logic                wr_clk,
   output logic                wr_en,
   output logic [BEATS*DW-1:0] wr_word,
   output logic                overflow
);
   localparam int PER = (MODE == CAP_DDR) ? 2 : 1;
   localparam int GW  = DW * PER;
   localparam int NG  = BEATS / PER;
   localparam int CW  = (NG > 1) ? $clog2(NG) : 1;
   localparam int WW  = BEATS * DW;

   initial begin : chk_params
      assert (BEATS >= 1 && BEATS <= MAX_BEATS && (BEATS % PER) == 0 && DW >= 1)
         else $error("scd_capture: unsupported BEATS/DW/MODE combination");
   end

   logic [GW-1:0] grp;
   logic [CW-1:0] cnt;
   logic [WW-1:0] acc, nxt;
   logic          last;

   generate
      if (MODE == CAP_DDR) begin : g_ddr
         logic [DW-1:0] rise_q;
         assign wr_clk = ~strobe;
         always_ff @(posedge strobe or negedge rst_n) begin
            if (!rst_n) rise_q <= '0;
            else        rise_q <= pin_data;
         end
         assign grp = {pin_data, rise_q};
      end else begin : g_sdr
         assign wr_clk = strobe;
         assign grp    = pin_data;
      end
   endgenerate

   always_comb begin
      nxt = acc;
      nxt[int'(cnt)*GW +: GW] = grp;
      last = (cnt == CW'(NG - 1));
   end

   assign wr_en   = last & ~full;
   assign wr_word = nxt;

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         cnt      <= '0;
         overflow <= 1'b0;
      end else begin
         acc <= nxt;
         cnt <= last ? '0 : cnt + 1'b1;
         if (last && full) overflow <= 1'b1;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge wr_clk) disable iff (!rst_n)
      int'(cnt) < NG); // R3
   AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (!rst_n)
      overflow |=> overflow); // R7
endmodule

// File: rtl/scd_afifo.sv
module scd_afifo #(
   parameter int WW    = 64,
   parameter int DEPTH = 4
) (
   input  logic          rst_n,
   input  logic          wr_clk,
   input  logic          wr_en,
   input  logic [WW-1:0] wr_word,
   output logic          full,
   input  logic          rd_clk,
   input  logic          rd_en,
   output logic [WW-1:0] rd_data,
   output logic          rd_valid,
   output logic          empty,
   output logic          underflow
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW:0] FULL_X = (AW+1)'(3) << (AW - 1);

   initial begin : chk_params
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("scd_afifo: DEPTH must be a power of two, at least 2");
   end

   logic [WW-1:0] mem [DEPTH];
   logic [AW:0]   wbin, wgray, rbin, rgray, rq_w, wq_r;
   logic [AW:0]   wbin_n, rbin_n;

   assign wbin_n = wbin + 1'b1;
   assign rbin_n = rbin + 1'b1;

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_en) begin
         wbin  <= wbin_n;
         wgray <= wbin_n ^ (wbin_n >> 1);
      end
   end

   always_ff @(posedge wr_clk) begin
      if (wr_en) mem[wbin[AW-1:0]] <= wr_word;
   end

   scd_sync #(.W(AW+1)) u_rsync (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rq_w));
   scd_sync #(.W(AW+1)) u_wsync (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wq_r));

   assign full  = ((wgray ^ rq_w) == FULL_X);
   assign empty = (rgray == wq_r);

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin      <= '0;
         rgray     <= '0;
         rd_data   <= '0;
         rd_valid  <= 1'b0;
         underflow <= 1'b0;
      end else begin
         rd_valid <= rd_en & ~empty;
         if (rd_en && !empty) begin
            rd_data <= mem[rbin[AW-1:0]];
            rbin    <= rbin_n;
            rgray   <= rbin_n ^ (rbin_n >> 1);
         end
         if (rd_en && empty) underflow <= 1'b1;
      end
   end

   AST_WR_NOT_FULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
      wr_en |-> !full); // R7
   AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1); // R8
   AST_RGRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $countones(rgray ^ $past(rgray)) <= 1); // R8
   AST_POP_ON_REQ: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rbin != $past(rbin)) |-> $past(rd_en)); // R5
   AST_UNF_STICKY: assert property (@(posedge rd_clk) disable iff (!rst_n)
      underflow |=> underflow); // R6
endmodule

// File: rtl/strobe_rd_deser.sv
module strobe_rd_deser
   import scd_pkg::*;
#(
   parameter int        DW    = 8,
   parameter int        BEATS = 8,
   parameter cap_mode_e MODE  = CAP_DDR,
   parameter int        DEPTH = 4
) (
   input  logic                rst_n,
   input  logic                strobe,
   input  logic [DW-1:0]       pin_data,
   input  logic                core_clk,
   input  logic                rd_en,
   output logic [BEATS*DW-1:0] rd_data,
   output logic                rd_valid,
   output logic                rd_empty,
   output logic                overflow,
   output logic                underflow
);
   localparam int WW = BEATS * DW;

   logic          wr_clk, wr_en, full;
   logic [WW-1:0] wr_word;

   scd_capture #(.DW(DW), .BEATS(BEATS), .MODE(MODE)) u_cap (
      .strobe(strobe), .rst_n(rst_n), .pin_data(pin_data), .full(full),
      .wr_clk(wr_clk), .wr_en(wr_en), .wr_word(wr_word), .overflow(overflow)
   );

   scd_afifo #(.WW(WW), .DEPTH(DEPTH)) u_fifo (
      .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_word(wr_word), .full(full),
      .rd_clk(core_clk), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
      .empty(rd_empty), .underflow(underflow)
   );
endmodule

// File: tb/strobe_rd_deser_tb_top.sv
`timescale 1ns/1ps
module strobe_rd_deser_tb_top;
   import scd_pkg::*;

   logic        core_clk = 1'b0;
   logic        rst_n    = 1'b0;
   logic        strobe_d = 1'b0, strobe_s = 1'b0;
   logic [7:0]  pin_d = '0, pin_s = '0;
   logic        rd_en = 1'b0, rd_en_s = 1'b0;
   logic [63:0] rd_data, rd_data_s;
   logic        rd_valid, rd_empty, overflow, underflow;
   logic        rd_valid_s, rd_empty_s, overflow_s, underflow_s;

   int nvec = 0, nfail = 0;
   bit done = 0;

   always #2.5 core_clk = ~core_clk;

   strobe_rd_deser #(.DW(8), .BEATS(8), .MODE(CAP_DDR), .DEPTH(4)) dut_i (
      .rst_n(rst_n), .strobe(strobe_d), .pin_data(pin_d), .core_clk(core_clk),
      .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .rd_empty(rd_empty),
      .overflow(overflow), .underflow(underflow));

   strobe_rd_deser #(.DW(8), .BEATS(8), .MODE(CAP_SDR), .DEPTH(4)) dut_sdr_i (
      .rst_n(rst_n), .strobe(strobe_s), .pin_data(pin_s), .core_clk(core_clk),
      .rd_en(rd_en_s), .rd_data(rd_data_s), .rd_valid(rd_valid_s), .rd_empty(rd_empty_s),
      .overflow(overflow_s), .underflow(underflow_s));

   // behavioural reference model of the double-rate instance
   logic [7:0]  beat_q[$];
   logic [63:0] word_q[$];
   logic [63:0] exp_data = '0;
   bit          exp_ovf = 0, exp_unf = 0, en_seen = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic void add_beat(input logic [7:0] b);
      logic [63:0] w;
      beat_q.push_back(b);
      if (beat_q.size() == 8) begin
         for (int i = 0; i < 8; i++) w[i*8 +: 8] = beat_q[i];
         beat_q.delete();
         if (word_q.size() < 4) word_q.push_back(w);
         else exp_ovf = 1;
      end
   endfunction

   task automatic ddr_pair(input logic [7:0] r, input logic [7:0] f);
      pin_d = r; #2 strobe_d = 1'b1; add_beat(r);
      #2 pin_d = f; #2 strobe_d = 1'b0; add_beat(f);
      #2;
   endtask

   task automatic ddr_word(input logic [63:0] w);
      for (int p = 0; p < 4; p++) ddr_pair(w[16*p +: 8], w[16*p+8 +: 8]);
   endtask

   task automatic sdr_beat(input logic [7:0] b);
      pin_s = b; #2 strobe_s = 1'b1; #4 strobe_s = 1'b0; #2;
   endtask

   task automatic wait_core(input int n);
      repeat (n) @(negedge core_clk);
   endtask

   task automatic pop(input int n);
      @(negedge core_clk); #1 rd_en = 1'b1;
      for (int i = 1; i < n; i++) @(negedge core_clk);
      @(negedge core_clk); #1 rd_en = 1'b0;
   endtask

   task automatic sdr_pop_chk(input logic [63:0] exp);
      @(negedge core_clk); #1 rd_en_s = 1'b1;
      @(negedge core_clk);
      chk("R4 valid", {63'd0, rd_valid_s}, 64'd1);
      chk("R4 data", rd_data_s, exp);
      #1 rd_en_s = 1'b0;
   endtask

   // per-clock comparison against the model (R5, R6)
   always @(posedge core_clk) en_seen <= rd_en;
   always @(negedge core_clk) begin
      if (rst_n && !done) begin
         logic expv;
         expv = 1'b0;
         if (en_seen) begin
            if (word_q.size() > 0) begin
               exp_data = word_q.pop_front();
               expv = 1'b1;
            end else exp_unf = 1;
         end
         chk("R5 rd_valid", {63'd0, rd_valid}, {63'd0, expv});
         chk("R5 R6 rd_data", rd_data, exp_data);
         chk("R6 underflow", {63'd0, underflow}, {63'd0, exp_unf});
      end
   end

   task automatic finish_run;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge core_clk);
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin : stim
      logic [63:0] w1, w2, w3, ws2;
      wait_core(3);
      // R1 reset state
      chk("R1 rd_empty", {63'd0, rd_empty}, 64'd1);
      chk("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
      chk("R1 overflow", {63'd0, overflow}, 64'd0);
      chk("R1 underflow", {63'd0, underflow}, 64'd0);
      chk("R1 sdr empty", {63'd0, rd_empty_s}, 64'd1);
      #1 rst_n = 1'b1;
      wait_core(3);

      // R9 split word, R3 visibility, R2 slot order
      ddr_pair(8'h10, 8'h11); ddr_pair(8'h12, 8'h13);
      wait_core(8);
      chk("R9 pending word not visible", {63'd0, rd_empty}, 64'd1);
      ddr_pair(8'h14, 8'h15); ddr_pair(8'h16, 8'h17);
      wait_core(3);
      chk("R3 word visible", {63'd0, rd_empty}, 64'd0);
      pop(1);
      wait_core(1);
      chk("R2 slot order", rd_data, 64'h1716151413121110);
      chk("R3 empty after pop", {63'd0, rd_empty}, 64'd1);

      // R2 R5 several patterns, back-to-back pops
      w1 = 64'h8040201008040201;
      w2 = 64'h55AA55AA55AA55AA;
      w3 = {$urandom, $urandom};
      ddr_word(w1); ddr_word(w2); ddr_word(w3);
      wait_core(4);
      pop(3);
      wait_core(1);
      chk("R2 R5 last of three", rd_data, w3);
      chk("R5 drained", {63'd0, rd_empty}, 64'd1);
      chk("R7 no overflow yet", {63'd0, overflow}, 64'd0);

      // R6 pop while empty
      pop(1);
      wait_core(2);
      chk("R6 still empty", {63'd0, rd_empty}, 64'd1);
      chk("R6 underflow set", {63'd0, underflow}, 64'd1);
      chk("R6 data held", rd_data, w3);

      // R4 single-rate instance
      for (int i = 0; i < 8; i++) sdr_beat(8'hA0 + 8'(i));
      ws2 = {$urandom, $urandom};
      for (int i = 0; i < 8; i++) sdr_beat(ws2[i*8 +: 8]);
      wait_core(4);
      sdr_pop_chk(64'hA7A6A5A4A3A2A1A0);
      sdr_pop_chk(ws2);
      wait_core(1);
      chk("R4 sdr drained", {63'd0, rd_empty_s}, 64'd1);

      // R7 overflow: five words into a four-entry FIFO
      for (int k = 0; k < 5; k++) ddr_word({$urandom, $urandom});
      #1;
      chk("R7 overflow set", {63'd0, overflow}, {63'd0, exp_ovf});
      wait_core(4);
      pop(4);
      wait_core(2);
      chk("R7 stored words drained", {63'd0, rd_empty}, 64'd1);
      chk("R7 overflow sticky", {63'd0, overflow}, 64'd1);

      wait_core(2);
      finish_run();
   end
endmodule